// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block collects 32 interrupt request lines, each from its own source, and records them in a status register. Each line can be set to detect rising edges, falling edges, a high level or a low level. Every request line passes through a two-flop synchroniser before detection. The status bits are gated by an enable mask. Each enabled, pending source is then steered to one of two processor-facing outputs, critical or non-critical. The non-critical output can also feed an input of another controller of the same kind.

Software reaches the block through a simple word-addressed register bus. Writes take effect on the clock edge. Reads are combinational from the address. All per-source registers use reversed bit numbering: source n sits at bit 31−n, so source 0 is the most significant bit. A read-only vector register gives the number of the highest-numbered source that is both pending and enabled.

Top module: `irq_ctrl32`

## Requirements
- R1: After reset, status, enable, critical select and trigger read 0, polarity reads 0xFFFFFFFF, vector configuration reads 0, both outputs are low and the vector reads 32.
- R2: Source n (input `irq_in[n]`) occupies bit 31−n of every per-source register: status 0x0, enable 0x2, critical select 0x3, polarity 0x4, trigger 0x5 and masked status 0x6.
- R3: With trigger bit 0 (level), a source whose synchronised input matches its polarity sets its status bit. Polarity 1 means the input is active when high; polarity 0 means it is active when low. The bit is readable three clock edges after the input changes.
- R4: With trigger bit 1 (edge), polarity 1 sets the status bit on a 0→1 transition and polarity 0 sets it on a 1→0 transition. A steady input sets nothing.
- R5: Writing to offset 0x0 clears every status bit written as 1 and leaves every bit written as 0 unchanged. Writing 0xFFFFFFFF clears all pending sources.
- R6: A level-triggered source that is still active is set again on every cycle, so a clear has no lasting effect until the input goes inactive.
- R7: When a set event and a clear reach the same status bit on the same edge, the bit stays set.
- R8: Offset 0x6 reads status AND enable. Writes to it are ignored.
- R9: Offset 0x7 reads the number of the highest-numbered source that is pending and enabled, or 32 when none is.
- R10: The critical output is the registered OR of the masked sources whose critical-select bit is 1. The non-critical output is the registered OR of the masked sources whose critical-select bit is 0. Each output follows the status by one clock edge.
- R11: The registers at 0x2, 0x3, 0x4, 0x5 and 0x8 read back what was written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_in | input | 32 | Request lines, bit n is source n |
| crit_irq | output | 1 | Critical interrupt output |
| ncrit_irq | output | 1 | Non-critical interrupt output, usable as a cascade source |

## Verification
The path from an input change to its status bit has three registers: two synchroniser flops, then the status flop. A status read is therefore taken only after the third rising edge following the input change. The outputs add one more register, so they are sampled after the fourth edge. Register writes and clears land on the edge under the write strobe, and reads sample half a cycle later. The set-versus-clear collision test places the write strobe on exactly the third edge after an edge input toggles.

// File: rtl/irq_ctrl32.sv
module irq_ctrl32 #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [3:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] irq_in,
  output logic            crit_irq,
  output logic            ncrit_irq
);
  localparam int VW = $clog2(NSRC + 1);

  logic [NSRC-1:0] src_bits, sync1, sync2, dly;
  logic [NSRC-1:0] stat_r, en_r, cs_r, pol_r, trg_r, vcfg_r;
  logic [NSRC-1:0] lvl_hit, edge_hit, set_ev, clr_mask, masked;
  logic [VW-1:0]   vec_idx;
  logic            stat_wr;

  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign src_bits[NSRC-1-n] = irq_in[n];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      dly   <= '0;
    end else begin
      sync1 <= src_bits;
      sync2 <= sync1;
      dly   <= sync2;
    end

  assign lvl_hit  = ~(sync2 ^ pol_r);
  assign edge_hit = (pol_r & sync2 & ~dly) | (~pol_r & ~sync2 & dly);
  assign set_ev   = (trg_r & edge_hit) | (~trg_r & lvl_hit);
  assign stat_wr  = bus_we && bus_addr == 4'h0;
  assign clr_mask = stat_wr ? bus_wdata[NSRC-1:0] : '0;
  assign masked   = stat_r & en_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat_r <= '0;
      en_r   <= '0;
      cs_r   <= '0;
      pol_r  <= '1;
      trg_r  <= '0;
      vcfg_r <= '0;
    end else begin
      stat_r <= (stat_r & ~clr_mask) | set_ev;
      if (bus_we)
        case (bus_addr)
          4'h2: en_r   <= bus_wdata[NSRC-1:0];
          4'h3: cs_r   <= bus_wdata[NSRC-1:0];
          4'h4: pol_r  <= bus_wdata[NSRC-1:0];
          4'h5: trg_r  <= bus_wdata[NSRC-1:0];
          4'h8: vcfg_r <= bus_wdata[NSRC-1:0];
          default: ;
        endcase
    end

  always_comb begin
    vec_idx = VW'(NSRC);
    for (int b = NSRC - 1; b >= 0; b--)
      if (masked[b]) vec_idx = VW'(NSRC - 1 - b);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      crit_irq  <= 1'b0;
      ncrit_irq <= 1'b0;
    end else begin
      crit_irq  <= |(masked & cs_r);
      ncrit_irq <= |(masked & ~cs_r);
    end

  always_comb
    case (bus_addr)
      4'h0: bus_rdata = 32'(stat_r);
      4'h2: bus_rdata = 32'(en_r);
      4'h3: bus_rdata = 32'(cs_r);
      4'h4: bus_rdata = 32'(pol_r);
      4'h5: bus_rdata = 32'(trg_r);
      4'h6: bus_rdata = 32'(masked);
      4'h7: bus_rdata = 32'(vec_idx);
      4'h8: bus_rdata = 32'(vcfg_r);
      default: bus_rdata = '0;
    endcase
endmodule

// File: rtl/irq_ctrl32_chk.sv
module irq_ctrl32_chk #(
  parameter int NSRC = 32,
  parameter int VW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stat_wr,
  input logic [NSRC-1:0] set_ev,
  input logic [NSRC-1:0] stat_r,
  input logic [NSRC-1:0] en_r,
  input logic [NSRC-1:0] cs_r,
  input logic [NSRC-1:0] trg_r,
  input logic [NSRC-1:0] masked,
  input logic [VW-1:0]   vec_idx,
  input logic            crit_irq,
  input logic            ncrit_irq
);
  AST_RESET_CFG: assert property (@(posedge clk) !rst_n |=> (en_r == '0 && cs_r == '0 && trg_r == '0)); // R1
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!$past(stat_wr) && $past(set_ev) == '0) |-> $stable(stat_r)); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) ($past(set_ev) & ~stat_r) == '0); // R7
  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_n) (vec_idx == VW'(NSRC)) == (masked == '0)); // R9
  AST_OUT_SRC: assert property (@(posedge clk) disable iff (!rst_n) (crit_irq || ncrit_irq) |-> $past(vec_idx != VW'(NSRC))); // R10
endmodule

bind irq_ctrl32 irq_ctrl32_chk #(.NSRC(NSRC), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .set_ev(set_ev),
  .stat_r(stat_r), .en_r(en_r), .cs_r(cs_r), .trg_r(trg_r),
  .masked(masked), .vec_idx(vec_idx), .crit_irq(crit_irq), .ncrit_irq(ncrit_irq)
);

// File: tb/irq_ctrl32_test.sv
module irq_ctrl32_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        crit_irq, ncrit_irq;
  int checks = 0;
  int fails = 0;

  irq_ctrl32 uut (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] rev(input logic [31:0] x);
    for (int i = 0; i < 32; i++) rev[31-i] = x[i];
  endfunction

  function automatic logic [31:0] exp_vec(input logic [31:0] m);
    exp_vec = 32;
    for (int n = 0; n < 32; n++) if (m[31-n]) exp_vec = n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, p, en, cs, m;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, d); chk("R1 status", d, 0);
    rd(4'h2, d); chk("R1 enable", d, 0);
    rd(4'h3, d); chk("R1 crit sel", d, 0);
    rd(4'h4, d); chk("R1 polarity", d, 32'hFFFF_FFFF);
    rd(4'h5, d); chk("R1 trigger", d, 0);
    rd(4'h8, d); chk("R1 vcfg", d, 0);
    rd(4'h7, d); chk("R1 vector", d, 32);
    chk("R1 outputs", {30'd0, crit_irq, ncrit_irq}, 0);
    // R11 readback
    wr(4'h2, 32'hA5A5_0F0F); rd(4'h2, d); chk("R11 enable", d, 32'hA5A5_0F0F);
    wr(4'h3, 32'h1234_5678); rd(4'h3, d); chk("R11 crit sel", d, 32'h1234_5678);
    wr(4'h5, 32'h0F00_0000); rd(4'h5, d); chk("R11 trigger", d, 32'h0F00_0000);
    wr(4'h8, 32'hDEAD_BEEF); rd(4'h8, d); chk("R11 vcfg", d, 32'hDEAD_BEEF);
    rd(4'h1, d); chk("R11 unmapped", d, 0);
    wr(4'h5, 0); wr(4'h2, 0); wr(4'h3, 0);
    // R2 mapping: source 0 at bit 31
    irq_in = 32'h1; settle(); rd(4'h0, d); chk("R2 source0 msb", d, 32'h8000_0000);
    irq_in = 32'h0; settle(); wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk("R5 clear all", d, 0);
    // R3 exact latency: status visible after third edge
    @(negedge clk); irq_in = 32'h8;
    repeat (2) @(posedge clk); #1 chk("R3 not before 3 edges", bus_rdata, 0);
    @(posedge clk); #1 chk("R3 after 3 edges", bus_rdata, 32'h1000_0000);
    // R6 level still active: clear does not stick
    wr(4'h0, 32'h1000_0000); rd(4'h0, d); chk("R6 active level re-sets", d, 32'h1000_0000);
    // R5 zero write no effect
    wr(4'h0, 32'h0); rd(4'h0, d); chk("R5 zero write", d, 32'h1000_0000);
    irq_in = 0; settle(); wr(4'h0, 32'h1000_0000); rd(4'h0, d); chk("R6 clear after inactive", d, 0);
    // R3 active low on source 5 (bit 26)
    wr(4'h4, ~32'h0400_0000); settle(); rd(4'h0, d); chk("R3 active low", d, 32'h0400_0000);
    irq_in[5] = 1'b1; settle(); wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk("R3 low inactive clear", d, 0);
    wr(4'h4, 32'hFFFF_FFFF); irq_in = 0; settle(); wr(4'h0, 32'hFFFF_FFFF);
    // R4 edge modes on source 7 (bit 24)
    wr(4'h5, 32'h0100_0000);
    irq_in[7] = 1'b1; settle(); rd(4'h0, d); chk("R4 rising sets", d, 32'h0100_0000);
    wr(4'h0, 32'h0100_0000); settle(); rd(4'h0, d); chk("R4 steady high no set", d, 0);
    wr(4'h4, ~32'h0100_0000); settle(); rd(4'h0, d); chk("R4 polarity change no set", d, 0);
    @(negedge clk); irq_in[7] = 1'b0; settle(); rd(4'h0, d); chk("R4 falling sets", d, 32'h0100_0000);
    wr(4'h4, 32'hFFFF_FFFF); wr(4'h0, 32'hFFFF_FFFF);
    // R7 collision on source 9 (bit 22), rising edge
    wr(4'h5, 32'h0040_0000);
    @(negedge clk); irq_in[9] = 1'b1;
    @(negedge clk);
    wr(4'h0, 32'h0040_0000);
    rd(4'h0, d); chk("R7 set wins", d, 32'h0040_0000);
    wr(4'h0, 32'h0040_0000); rd(4'h0, d); chk("R5 edge clear", d, 0);
    irq_in = 0; wr(4'h5, 0); settle(); wr(4'h0, 32'hFFFF_FFFF);
    // R8 write to masked ignored
    irq_in = 32'h3; wr(4'h2, 32'h4000_0000); settle();
    wr(4'h6, 32'hFFFF_FFFF); rd(4'h6, d); chk("R8 masked ro", d, 32'h4000_0000);
    rd(4'h0, d); chk("R8 status kept", d, 32'hC000_0000);
    irq_in = 0; settle(); wr(4'h0, 32'hFFFF_FFFF); wr(4'h2, 0);
    // random level-high patterns: R3 R8 R9 R10
    for (int it = 0; it < 24; it++) begin
      p = $urandom; en = $urandom; cs = $urandom;
      if (it == 0) en = 0;
      if (it == 1) p = 0;
      wr(4'h2, en); wr(4'h3, cs);
      @(negedge clk); irq_in = p;
      settle();
      m = rev(p) & en;
      rd(4'h0, d); chk("R3 random status", d, rev(p));
      rd(4'h6, d); chk("R8 random masked", d, m);
      rd(4'h7, d); chk("R9 random vector", d, exp_vec(m));
      chk("R10 crit", {31'd0, crit_irq}, {31'd0, |(m & cs)});
      chk("R10 ncrit", {31'd0, ncrit_irq}, {31'd0, |(m & ~cs)});
      irq_in = 0; settle(); wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d); chk("R5 random clear", d, 0);
    end
    rd(4'h7, d); chk("R9 none pending", d, 32);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule